// File: doc/BRIEF.md
# Affinity-Steered Interrupt Distributor

This block takes a set of external interrupt request lines and hands each request to one of several processor cores. Software gives every source a target mask, one bit per core, through a single write port. A source whose mask holds a single core is always sent to that core. A source whose mask holds several cores is sent to them in turn, so that its load is spread over all the cores it is allowed to use.

Each source has a pending latch that is set by a rising edge or by a high level, as chosen per source. Each core sees at most one offered source at a time, as a valid flag with a source number. The core takes the offer by raising its acknowledge for one cycle. That clears the pending latch of the source and moves that source's rotation onward. After reset every source targets core 0 only, so the boot core gets all requests until software spreads them.

Top module: `irq_affinity_dist`

## Requirements
- R1: After reset no core has an offer and every source's target mask holds only core 0 (mask value 1, bit i = core i), so a source that fires with no mask write is offered to core 0.
- R2: A source whose mask holds exactly one core is offered only to that core on every occurrence.
- R3: A source whose mask holds several cores is offered to them in rising core order with wrap-around, skipping cores outside the mask. After reset its rotation starts at core 0, and it moves past a core only when that core acknowledges the source.
- R4: A source is never offered to two cores at the same time.
- R5: A source with an all-zero mask stays pending but is not offered. Once a non-zero mask is written, the request is offered according to the new mask.
- R6: In edge mode (mode bit 1) a rising edge of the line makes exactly one offer. A line held high after that makes no further offers.
- R7: In level mode (mode bit 0), a line that is still high when its offer is acknowledged is offered again. A line that is low when the offer is acknowledged leaves nothing pending.
- R8: When several sources wait for the same core, the lowest-numbered source is offered first and the others follow after each acknowledge.
- R9: An offer keeps its valid flag and source number unchanged until the core acknowledges. On the edge where the acknowledge is taken, the offer is withdrawn.
- R10: Writing a source's mask while that source is on offer does not withdraw or move the offer. The new mask applies from the next delivery.
- R11: Each source has its own rotation, so deliveries of one source do not move the rotation of another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_in | input | NUM_SRC | Interrupt request lines, one per source |
| trig_edge | input | NUM_SRC | Per-source mode: 1 = rising edge, 0 = level |
| cfg_we | input | 1 | Mask write strobe |
| cfg_src | input | SW | Source whose mask is written |
| cfg_mask | input | NUM_CORE | New target mask, bit i = core i |
| core_valid | output | NUM_CORE | Per-core offer valid |
| core_src | output | NUM_CORE*SW | Per-core offered source number, core i in bits i*SW +: SW |
| core_ack | input | NUM_CORE | Per-core acknowledge of the current offer |

## Verification
The assertions assume that a core raises its acknowledge only while it holds an offer, that mask writes name an existing source, and that a source's mode bit does not change while that source is pending. The bench drives all inputs on falling clock edges. It raises an acknowledge only after it has seen the matching offer and holds it for one cycle. It makes one mask write per cycle with an index below the source count, and it changes a mode bit only while the source is idle.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;

    localparam int DEF_SRC  = 8;
    localparam int DEF_CORE = 4;

    typedef enum logic {
        TRIG_LEVEL = 1'b0,
        TRIG_EDGE  = 1'b1
    } trig_e;

    // Width of an index into n items, at least one bit.
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Next position in a ring of n slots.
    function automatic int ring_next(input int pos, input int n);
        return (pos >= n - 1) ? 0 : pos + 1;
    endfunction

endpackage

// File: rtl/irq_dist_slot.sv
module irq_dist_slot
    import irq_dist_pkg::*;
#(
    parameter int NC = DEF_CORE,
    localparam int CW = idx_w(NC)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          irq,
    input  trig_e         trig,
    input  logic          cfg_hit,
    input  logic [NC-1:0] cfg_mask,
    input  logic          clr,
    input  logic [CW-1:0] clr_core,
    input  logic          inflight,
    output logic          pending,
    output logic          want,
    output logic [CW-1:0] want_core
);

    logic          irq_q;
    logic [NC-1:0] mask_q;
    logic [CW-1:0] ptr_q;
    logic          set;
    logic          found;
    int            j;

    assign set = (trig == TRIG_EDGE) ? (irq & ~irq_q) : irq;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q   <= 1'b0;
            pending <= 1'b0;
            mask_q  <= NC'(1);
            ptr_q   <= '0;
        end else begin
            irq_q   <= irq;
            pending <= (pending & ~clr) | set;
            if (cfg_hit)
                mask_q <= cfg_mask;
            if (clr)
                ptr_q <= CW'(ring_next(int'(clr_core), NC));
        end
    end

    // First mask member at or after the rotation pointer.
    always_comb begin
        found     = 1'b0;
        want_core = '0;
        j         = 0;
        for (int k = 0; k < NC; k++) begin
            j = (int'(ptr_q) + k) % NC;
            if (!found && mask_q[j]) begin
                found     = 1'b1;
                want_core = CW'(j);
            end
        end
    end

    assign want = pending & ~inflight & found;

    // R2 / R3: the chosen core is always a member of the mask
    a_r3_pick_in_mask: assert property (@(posedge clk) disable iff (rst)
        want |-> mask_q[want_core]);

    // R5: a zero mask never produces a request
    a_r5_zero_mask_silent: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |-> !want);

    // R7: an acknowledge with no new trigger leaves nothing pending
    a_r7_clear_drops: assert property (@(posedge clk) disable iff (rst)
        (clr && !set) |=> !pending);

endmodule

// File: rtl/irq_dist_port.sv
module irq_dist_port
    import irq_dist_pkg::*;
#(
    parameter int NS   = DEF_SRC,
    parameter int NC   = DEF_CORE,
    parameter int CIDX = 0,
    localparam int SW  = idx_w(NS),
    localparam int CW  = idx_w(NC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NS-1:0]    want,
    input  logic [NS*CW-1:0] want_core,
    input  logic             ack,
    output logic             valid,
    output logic [SW-1:0]    src_id
);

    logic          hit;
    logic [SW-1:0] sel;

    // Lowest-numbered source aimed at this core wins.
    always_comb begin
        hit = 1'b0;
        sel = '0;
        for (int s = 0; s < NS; s++) begin
            if (!hit && want[s] && (want_core[s*CW +: CW] == CW'(CIDX))) begin
                hit = 1'b1;
                sel = SW'(s);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid  <= 1'b0;
            src_id <= '0;
        end else if (valid) begin
            if (ack)
                valid <= 1'b0;
        end else if (hit) begin
            valid  <= 1'b1;
            src_id <= sel;
        end
    end

    // R9: offer is held until taken
    a_r9_hold_offer: assert property (@(posedge clk) disable iff (rst)
        (valid && !ack) |=> (valid && $stable(src_id)));

    // R9: acknowledge withdraws the offer
    a_r9_ack_release: assert property (@(posedge clk) disable iff (rst)
        (valid && ack) |=> !valid);

endmodule

// File: rtl/irq_affinity_dist.sv
module irq_affinity_dist
    import irq_dist_pkg::*;
#(
    parameter int NUM_SRC  = DEF_SRC,
    parameter int NUM_CORE = DEF_CORE,
    localparam int SW = idx_w(NUM_SRC),
    localparam int CW = idx_w(NUM_CORE)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_SRC-1:0]     irq_in,
    input  logic [NUM_SRC-1:0]     trig_edge,
    input  logic                   cfg_we,
    input  logic [SW-1:0]          cfg_src,
    input  logic [NUM_CORE-1:0]    cfg_mask,
    output logic [NUM_CORE-1:0]    core_valid,
    output logic [NUM_CORE*SW-1:0] core_src,
    input  logic [NUM_CORE-1:0]    core_ack
);

    logic [NUM_SRC-1:0]    pending;
    logic [NUM_SRC-1:0]    want;
    logic [NUM_SRC*CW-1:0] want_core;
    logic [NUM_SRC-1:0]    clr;
    logic [NUM_SRC*CW-1:0] clr_core;
    logic [NUM_SRC-1:0]    inflight;
    logic [NUM_CORE-1:0]   owners [NUM_SRC];

    // Which cores currently hold each source, and which take it now.
    always_comb begin
        clr      = '0;
        clr_core = '0;
        inflight = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            owners[s] = '0;
            for (int c = 0; c < NUM_CORE; c++) begin
                if (core_valid[c] && (core_src[c*SW +: SW] == SW'(s))) begin
                    owners[s][c] = 1'b1;
                    inflight[s]  = 1'b1;
                    if (core_ack[c]) begin
                        clr[s]                = 1'b1;
                        clr_core[s*CW +: CW]  = CW'(c);
                    end
                end
            end
        end
    end

    generate
        for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
            irq_dist_slot #(.NC(NUM_CORE)) u_slot (
                .clk       (clk),
                .rst       (rst),
                .irq       (irq_in[s]),
                .trig      (trig_e'(trig_edge[s])),
                .cfg_hit   (cfg_we && (cfg_src == SW'(s))),
                .cfg_mask  (cfg_mask),
                .clr       (clr[s]),
                .clr_core  (clr_core[s*CW +: CW]),
                .inflight  (inflight[s]),
                .pending   (pending[s]),
                .want      (want[s]),
                .want_core (want_core[s*CW +: CW])
            );

            // R4: one owner at most
            a_r4_single_owner: assert property (@(posedge clk) disable iff (rst)
                $countones(owners[s]) <= 1);
        end

        for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
            irq_dist_port #(.NS(NUM_SRC), .NC(NUM_CORE), .CIDX(c)) u_port (
                .clk       (clk),
                .rst       (rst),
                .want      (want),
                .want_core (want_core),
                .ack       (core_ack[c]),
                .valid     (core_valid[c]),
                .src_id    (core_src[c*SW +: SW])
            );

            // R9: an offered source stays pending until acknowledged
            a_r9_offer_pending: assert property (@(posedge clk) disable iff (rst)
                core_valid[c] |-> pending[core_src[c*SW +: SW]]);
        end
    endgenerate

endmodule

// File: tb/irq_affinity_dist_tb.sv
module irq_affinity_dist_tb;

    localparam int NS = 8;
    localparam int NC = 4;
    localparam int SW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NS-1:0] irq_in = '0;
    logic [NS-1:0] trig_edge = '1;
    logic          cfg_we = 1'b0;
    logic [SW-1:0] cfg_src = '0;
    logic [NC-1:0] cfg_mask = '0;
    logic [NC-1:0] core_valid;
    logic [NC*SW-1:0] core_src;
    logic [NC-1:0] core_ack = '0;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    irq_affinity_dist u_dut (
        .clk        (clk),
        .rst        (rst),
        .irq_in     (irq_in),
        .trig_edge  (trig_edge),
        .cfg_we     (cfg_we),
        .cfg_src    (cfg_src),
        .cfg_mask   (cfg_mask),
        .core_valid (core_valid),
        .core_src   (core_src),
        .core_ack   (core_ack)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic fire(input int s);
        irq_in[s] = 1'b1;
        tick();
        irq_in[s] = 1'b0;
    endtask

    task automatic set_mask(input int s, input logic [NC-1:0] m);
        cfg_we   = 1'b1;
        cfg_src  = SW'(s);
        cfg_mask = m;
        tick();
        cfg_we   = 1'b0;
    endtask

    // Wait for an offer on core c and compare its source number.
    task automatic expect_offer(input int c, input int s, input string tag);
        int n = 0;
        while (!core_valid[c] && n < 12) begin
            tick();
            n++;
        end
        chk(core_valid[c] && (int'(core_src[c*SW +: SW]) == s), tag,
            core_valid[c] ? int'(core_src[c*SW +: SW]) : -1, s);
        chk(core_valid == NC'(1 << c), {tag, " only-core"}, int'(core_valid), 1 << c);
    endtask

    task automatic take(input int c);
        core_ack[c] = 1'b1;
        tick();
        core_ack[c] = 1'b0;
        chk(!core_valid[c], "R9 withdrawn after ack", int'(core_valid[c]), 0);
    endtask

    task automatic expect_idle(input int n, input string tag);
        for (int i = 0; i < n; i++) tick();
        chk(core_valid == '0, tag, int'(core_valid), 0);
    endtask

    task automatic t_reset();
        chk(core_valid == '0, "R1 no offer after reset", int'(core_valid), 0);
        fire(3);
        expect_offer(0, 3, "R1 default mask core0");
        take(0);
    endtask

    task automatic t_single();
        set_mask(1, 4'b0100);
        fire(1);
        expect_offer(2, 1, "R2 single core first");
        take(2);
        fire(1);
        expect_offer(2, 1, "R2 single core again");
        take(2);
    endtask

    task automatic t_rotate();
        set_mask(5, 4'b1010);
        fire(5);
        expect_offer(1, 5, "R3 rotate first core1");
        take(1);
        fire(5);
        expect_offer(3, 5, "R3 rotate skip to core3");
        take(3);
        fire(5);
        expect_offer(1, 5, "R3 rotate wrap to core1");
        take(1);
    endtask

    task automatic t_indep();
        set_mask(4, 4'b0011);
        set_mask(6, 4'b0011);
        fire(4);
        expect_offer(0, 4, "R11 src4 core0");
        take(0);
        fire(4);
        expect_offer(1, 4, "R11 src4 core1");
        take(1);
        fire(6);
        expect_offer(0, 6, "R11 src6 own pointer core0");
        take(0);
    endtask

    task automatic t_priority();
        irq_in[7] = 1'b1;
        irq_in[2] = 1'b1;
        tick();
        irq_in = '0;
        expect_offer(0, 2, "R8 lowest first");
        take(0);
        expect_offer(0, 7, "R8 next after ack");
        take(0);
    endtask

    task automatic t_zero_mask();
        set_mask(7, 4'b0000);
        fire(7);
        expect_idle(8, "R5 zero mask not offered");
        set_mask(7, 4'b1000);
        expect_offer(3, 7, "R5 offered after mask write");
        take(3);
    endtask

    task automatic t_inflight();
        fire(0);
        expect_offer(0, 0, "R10 initial core0");
        set_mask(0, 4'b0100);
        for (int i = 0; i < 4; i++) tick();
        chk(core_valid == 4'b0001 && core_src[SW-1:0] == '0, "R10 offer not recalled",
            int'(core_valid), 1);
        take(0);
        fire(0);
        expect_offer(2, 0, "R10 new mask next time");
        take(2);
    endtask

    task automatic t_edge();
        irq_in[1] = 1'b1;
        expect_offer(2, 1, "R6 edge offer");
        take(2);
        expect_idle(6, "R6 held line no repeat");
        irq_in[1] = 1'b0;
        expect_idle(2, "R6 release no offer");
    endtask

    task automatic t_level();
        trig_edge[2] = 1'b0;
        irq_in[2] = 1'b1;
        expect_offer(0, 2, "R7 level offer");
        take(0);
        expect_offer(0, 2, "R7 level re-offer while high");
        irq_in[2] = 1'b0;
        tick();
        take(0);
        expect_idle(6, "R7 level low no re-offer");
        trig_edge[2] = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_single();
        t_rotate();
        t_indep();
        t_priority();
        t_zero_mask();
        t_inflight();
        t_edge();
        t_level();
        tick();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule